// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is a hardwired control unit joined to a small register-transfer datapath for a one-register machine. Every clock edge performs one group of register transfers. Which group runs is chosen by a two-bit phase code together with a step counter. The datapath holds the following registers:

- the program counter (`pc`)
- the memory address register (`mar`)
- the memory buffer register (`mbr`)
- the instruction register (`ir`), which carries an opcode, an indirect flag and an address
- one working register, R1, brought out as `acc_o`

The block drives a synchronous single-port memory. A read strobe sampled at one clock edge returns data on `mem_rdata` during the following cycle. The `mbr` captures that data at the end of the same cycle.

The sequencer is a state machine whose states are the four phases:

| State | Code |
|---|---|
| `PH_FETCH` | 2'b00 |
| `PH_INDIRECT` | 2'b01 |
| `PH_EXECUTE` | 2'b10 |
| `PH_INTERRUPT` | 2'b11 |

Its transitions are:

- **FETCH→INDIRECT**: the fetched word has its indirect flag set.
- **FETCH→EXECUTE**: the fetched word has its indirect flag clear.
- **INDIRECT→EXECUTE**: always, once the indirect phase ends.
- **EXECUTE→INTERRUPT**: the request is high and interrupts are enabled.
- **EXECUTE→FETCH**: otherwise.
- **INTERRUPT→FETCH**: always, once the interrupt phase ends.

The step counter returns to its first step on every transition. The instruction set covers three operations: add to R1, increment-and-skip-if-zero, and branch-with-return-address.

Top module: `microseq_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `acc_o` read zero, `phase_o` reads 2'b00 and `step_o` reads 0 (step index 0 is the first timed step). Interrupts become enabled.
- R2: The fetch phase takes three cycles.
  - Step 0 raises `mem_rd` with `mem_addr` equal to the PC.
  - Step 1 captures memory into the MBR and advances the PC by one.
  - Step 2 copies the MBR into the IR.
  - Instruction word layout: opcode in bits [15:12], indirect flag in bit 11, address in bits [10:0].
- R3: When bit 11 of the fetched word is set, a three-cycle indirect phase (code 2'b01) runs before execute. It reads the word at the address field and replaces the IR address with bits [10:0] of that word.
- R4: Opcode 4'h1 (ADD) executes in three cycles and leaves R1 = R1 + mem[address], modulo 2^16.
- R5: Opcode 4'h2 (ISZ) executes in four cycles and writes mem[address]+1 back to memory. When the new value is zero, the PC is advanced once more so the next word is skipped.
- R6: Opcode 4'h3 (BSA) executes in three cycles.
  - It stores the address of the following instruction at the target address.
  - The PC then becomes the target address plus one.
- R7: Every other opcode spends one execute cycle. It issues no memory access and leaves R1 unchanged.
- R8: When `irq` is high and interrupts are enabled at the end of execute, a three-cycle interrupt phase (code 2'b11) runs.
  - It writes the PC to `SAVE_ADDR` and loads `ROUTINE_ADDR` into the PC.
  - It disables further interrupts until the next reset.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle.
- R10: Whenever the phase code changes, the step counter restarts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 16 | Memory write data (the MBR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| phase_o | output | 2 | Current phase code |
| step_o | output | 3 | Current step index within the phase |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Working register R1 |

## Verification
The hardest situation to bring about is the interrupt entry followed by the proof that a second entry is suppressed. That proof requires the request to stay high through a whole further instruction and still see the sequencer go from execute back to fetch. The stimulus holds `irq` high from reset and places a no-op at the routine address. It then times two complete instructions and counts how often the interrupt phase starts. The ISZ skip is also hard to reach, because it needs a stored value that wraps to zero. It is reached by seeding the operand with 16'hFFFF and comparing the PC and the cycle count with a non-wrapping case.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

    localparam int unsigned OP_W = 4;

    localparam logic [OP_W-1:0] OPC_ADD = 4'h1;
    localparam logic [OP_W-1:0] OPC_ISZ = 4'h2;
    localparam logic [OP_W-1:0] OPC_BSA = 4'h3;

    typedef enum logic [1:0] {
        PH_FETCH     = 2'b00,
        PH_INDIRECT  = 2'b01,
        PH_EXECUTE   = 2'b10,
        PH_INTERRUPT = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        MARS_PC   = 2'd0,
        MARS_IRA  = 2'd1,
        MARS_SAVE = 2'd2
    } mar_src_e;

    typedef enum logic [1:0] {
        MBRS_MEM = 2'd0,
        MBRS_PC  = 2'd1,
        MBRS_INC = 2'd2
    } mbr_src_e;

    typedef enum logic {
        PCS_IRA     = 1'b0,
        PCS_ROUTINE = 1'b1
    } pc_src_e;

    typedef struct packed {
        logic     mar_ld;
        mar_src_e mar_src;
        logic     mbr_ld;
        mbr_src_e mbr_src;
        logic     pc_ld;
        pc_src_e  pc_src;
        logic     pc_inc;
        logic     pc_skip;
        logic     ir_ld;
        logic     ir_addr_ld;
        logic     acc_add;
        logic     mem_rd;
        logic     mem_wr;
        logic     done;
    } ctl_t;

endpackage

// File: rtl/microseq_sequencer.sv
module microseq_sequencer
    import microseq_pkg::*;
#(
    parameter int unsigned STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_done,
    input  logic              fetched_indirect,
    input  logic              irq,
    output phase_e            phase,
    output logic [STEP_W-1:0] step
);

    phase_e            phase_n;
    logic [STEP_W-1:0] step_n;
    logic              irq_en;
    logic              take_irq;

    assign take_irq = irq && irq_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_FETCH;
            step   <= '0;
            irq_en <= 1'b1;
        end else begin
            phase <= phase_n;
            step  <= step_n;
            if (phase_n == PH_INTERRUPT && phase != PH_INTERRUPT) begin
                irq_en <= 1'b0;
            end
        end
    end

    // next-state decision
    always_comb begin
        phase_n = phase;
        step_n  = step + 1'b1;
        if (phase_done) begin
            step_n = '0;
            unique case (phase)
                PH_FETCH:     phase_n = fetched_indirect ? PH_INDIRECT : PH_EXECUTE;
                PH_INDIRECT:  phase_n = PH_EXECUTE;
                PH_EXECUTE:   phase_n = take_irq ? PH_INTERRUPT : PH_FETCH;
                PH_INTERRUPT: phase_n = PH_FETCH;
                default:      phase_n = PH_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/microseq_decode.sv
module microseq_decode
    import microseq_pkg::*;
#(
    parameter int unsigned STEP_W = 3
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  logic [OP_W-1:0]   opcode,
    output ctl_t              ctl
);

    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_FETCH: begin
                case (int'(step))
                    0: begin
                        ctl.mar_ld  = 1'b1;
                        ctl.mar_src = MARS_PC;
                        ctl.mem_rd  = 1'b1;
                    end
                    1: begin
                        ctl.mbr_ld  = 1'b1;
                        ctl.mbr_src = MBRS_MEM;
                        ctl.pc_inc  = 1'b1;
                    end
                    2: begin
                        ctl.ir_ld = 1'b1;
                        ctl.done  = 1'b1;
                    end
                    default: ctl.done = 1'b1;
                endcase
            end
            PH_INDIRECT: begin
                case (int'(step))
                    0: begin
                        ctl.mar_ld  = 1'b1;
                        ctl.mar_src = MARS_IRA;
                        ctl.mem_rd  = 1'b1;
                    end
                    1: begin
                        ctl.mbr_ld  = 1'b1;
                        ctl.mbr_src = MBRS_MEM;
                    end
                    2: begin
                        ctl.ir_addr_ld = 1'b1;
                        ctl.done       = 1'b1;
                    end
                    default: ctl.done = 1'b1;
                endcase
            end
            PH_EXECUTE: begin
                if (opcode == OPC_ADD || opcode == OPC_ISZ) begin
                    case (int'(step))
                        0: begin
                            ctl.mar_ld  = 1'b1;
                            ctl.mar_src = MARS_IRA;
                            ctl.mem_rd  = 1'b1;
                        end
                        1: begin
                            ctl.mbr_ld  = 1'b1;
                            ctl.mbr_src = MBRS_MEM;
                        end
                        2: begin
                            if (opcode == OPC_ADD) begin
                                ctl.acc_add = 1'b1;
                                ctl.done    = 1'b1;
                            end else begin
                                ctl.mbr_ld  = 1'b1;
                                ctl.mbr_src = MBRS_INC;
                            end
                        end
                        3: begin
                            ctl.mem_wr  = 1'b1;
                            ctl.pc_skip = 1'b1;
                            ctl.done    = 1'b1;
                        end
                        default: ctl.done = 1'b1;
                    endcase
                end else if (opcode == OPC_BSA) begin
                    case (int'(step))
                        0: begin
                            ctl.mar_ld  = 1'b1;
                            ctl.mar_src = MARS_IRA;
                            ctl.mbr_ld  = 1'b1;
                            ctl.mbr_src = MBRS_PC;
                        end
                        1: begin
                            ctl.pc_ld  = 1'b1;
                            ctl.pc_src = PCS_IRA;
                            ctl.mem_wr = 1'b1;
                        end
                        2: begin
                            ctl.pc_inc = 1'b1;
                            ctl.done   = 1'b1;
                        end
                        default: ctl.done = 1'b1;
                    endcase
                end else begin
                    ctl.done = 1'b1;
                end
            end
            PH_INTERRUPT: begin
                case (int'(step))
                    0: begin
                        ctl.mbr_ld  = 1'b1;
                        ctl.mbr_src = MBRS_PC;
                    end
                    1: begin
                        ctl.mar_ld  = 1'b1;
                        ctl.mar_src = MARS_SAVE;
                        ctl.pc_ld   = 1'b1;
                        ctl.pc_src  = PCS_ROUTINE;
                    end
                    2: begin
                        ctl.mem_wr = 1'b1;
                        ctl.done   = 1'b1;
                    end
                    default: ctl.done = 1'b1;
                endcase
            end
            default: ctl.done = 1'b1;
        endcase
    end

endmodule

// File: rtl/microseq_datapath.sv
module microseq_datapath
    import microseq_pkg::*;
#(
    parameter int unsigned           ADDR_W       = 11,
    parameter logic [ADDR_W-1:0]     SAVE_ADDR    = 11'h7F0,
    parameter logic [ADDR_W-1:0]     ROUTINE_ADDR = 11'h7F1,
    localparam int unsigned          WORD_W       = OP_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [OP_W-1:0]   opcode,
    output logic              fetched_indirect,
    output logic [ADDR_W-1:0] pc_q,
    output logic [WORD_W-1:0] acc_q
);

    localparam int unsigned IND_BIT = ADDR_W;

    logic [ADDR_W-1:0] mar_q;
    logic [ADDR_W-1:0] mar_d;
    logic [WORD_W-1:0] mbr_q;
    logic [WORD_W-1:0] mbr_d;
    logic [WORD_W-1:0] ir_q;
    logic [ADDR_W-1:0] ir_addr;
    logic              mbr_zero;

    assign ir_addr  = ir_q[ADDR_W-1:0];
    assign mbr_zero = (mbr_q == '0);

    always_comb begin
        mar_d = pc_q;
        unique case (ctl.mar_src)
            MARS_PC:   mar_d = pc_q;
            MARS_IRA:  mar_d = ir_addr;
            MARS_SAVE: mar_d = SAVE_ADDR;
            default:   mar_d = pc_q;
        endcase
    end

    always_comb begin
        mbr_d = mem_rdata;
        unique case (ctl.mbr_src)
            MBRS_MEM: mbr_d = mem_rdata;
            MBRS_PC:  mbr_d = WORD_W'(pc_q);
            MBRS_INC: mbr_d = mbr_q + 1'b1;
            default:  mbr_d = mem_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.mar_ld) begin
                mar_q <= mar_d;
            end
            if (ctl.mbr_ld) begin
                mbr_q <= mbr_d;
            end
            if (ctl.pc_ld) begin
                pc_q <= (ctl.pc_src == PCS_ROUTINE) ? ROUTINE_ADDR : ir_addr;
            end else if (ctl.pc_inc || (ctl.pc_skip && mbr_zero)) begin
                pc_q <= pc_q + 1'b1;
            end
            if (ctl.ir_ld) begin
                ir_q <= mbr_q;
            end else if (ctl.ir_addr_ld) begin
                ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
            end
            if (ctl.acc_add) begin
                acc_q <= acc_q + mbr_q;
            end
        end
    end

    assign mem_addr         = ctl.mar_ld ? mar_d : mar_q;
    assign mem_wdata        = mbr_q;
    assign opcode           = ir_q[WORD_W-1 -: OP_W];
    assign fetched_indirect = mbr_q[IND_BIT];

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
    import microseq_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 11,
    parameter int unsigned       STEP_W       = 3,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h7F0,
    parameter logic [ADDR_W-1:0] ROUTINE_ADDR = 11'h7F1,
    localparam int unsigned      WORD_W       = OP_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [1:0]        phase_o,
    output logic [STEP_W-1:0] step_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] acc_o
);

    phase_e            phase;
    logic [STEP_W-1:0] step;
    ctl_t              ctl;
    logic [OP_W-1:0]   ir_opcode;
    logic              fetched_indirect;

    microseq_sequencer #(
        .STEP_W (STEP_W)
    ) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .phase_done       (ctl.done),
        .fetched_indirect (fetched_indirect),
        .irq              (irq),
        .phase            (phase),
        .step             (step)
    );

    microseq_decode #(
        .STEP_W (STEP_W)
    ) u_dec (
        .phase  (phase),
        .step   (step),
        .opcode (ir_opcode),
        .ctl    (ctl)
    );

    microseq_datapath #(
        .ADDR_W       (ADDR_W),
        .SAVE_ADDR    (SAVE_ADDR),
        .ROUTINE_ADDR (ROUTINE_ADDR)
    ) u_dp (
        .clk              (clk),
        .rst_n            (rst_n),
        .ctl              (ctl),
        .mem_rdata        (mem_rdata),
        .mem_addr         (mem_addr),
        .mem_wdata        (mem_wdata),
        .opcode           (ir_opcode),
        .fetched_indirect (fetched_indirect),
        .pc_q             (pc_o),
        .acc_q            (acc_o)
    );

    assign mem_rd  = ctl.mem_rd;
    assign mem_wr  = ctl.mem_wr;
    assign phase_o = phase;
    assign step_o  = step;

endmodule

// File: rtl/microseq_ctrl_chk.sv
module microseq_ctrl_chk #(
    parameter int unsigned       ADDR_W       = 11,
    parameter int unsigned       STEP_W       = 3,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h7F0,
    parameter logic [ADDR_W-1:0] ROUTINE_ADDR = 11'h7F1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase,
    input logic [STEP_W-1:0] step,
    input logic [ADDR_W-1:0] pc,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        opcode
);

    // R9
    no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (step == '0));

    // R2
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && step == '0) |-> (mem_rd && mem_addr == pc));

    // R2
    fetch_pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && step == STEP_W'(1)) |=> (pc == $past(pc) + 1'b1));

    // R8
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && step == STEP_W'(1))
        |=> (pc == ROUTINE_ADDR && mem_wr && mem_addr == SAVE_ADDR));

    // R7
    nop_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && step == '0 && opcode != 4'h1 && opcode != 4'h2 && opcode != 4'h3)
        |-> (!mem_rd && !mem_wr));

endmodule

bind microseq_ctrl microseq_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .STEP_W       (STEP_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .ROUTINE_ADDR (ROUTINE_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_o),
    .step     (step_o),
    .pc       (pc_o),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .opcode   (ir_opcode)
);

// File: tb/microseq_ctrl_test.sv
`timescale 1ns/1ps
module microseq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd;
    logic        mem_wr;
    logic [1:0]  phase_o;
    logic [2:0]  step_o;
    logic [10:0] pc_o;
    logic [15:0] acc_o;

    logic        tb_we = 1'b0;
    logic [10:0] tb_a  = '0;
    logic [15:0] tb_d  = '0;
    logic [15:0] mem [0:2047] = '{default: 16'h0000};

    int checks   = 0;
    int failures = 0;
    int wr_count = 0;
    int int_entries = 0;
    int overlap_count = 0;
    int restart_errs = 0;
    logic [1:0] prev_phase = 2'b00;

    always #2.5 clk = ~clk;

    microseq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .phase_o   (phase_o),
        .step_o    (step_o),
        .pc_o      (pc_o),
        .acc_o     (acc_o)
    );

    // synchronous single-port memory, one-cycle read latency
    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // port monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr) wr_count++;
            if (mem_rd && mem_wr) overlap_count++;
            if (phase_o == 2'b11 && step_o == 3'd0) int_entries++;
            if (phase_o != prev_phase && step_o != 3'd0) restart_errs++;
        end
        prev_phase = phase_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load(input logic [10:0] a, input logic [15:0] d);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic go();
        rst_n = 1'b1;
    endtask

    task automatic run_instr(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!(phase_o == 2'b00 && step_o == 3'd0) && cyc < 64);
    endtask

    // {operand a, operand b, expected R1}
    localparam logic [47:0] ADD_VEC [4] = '{
        {16'h0001, 16'h0002, 16'h0003},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h7FFF, 16'h7FFF, 16'hFFFE},
        {16'h1234, 16'h0000, 16'h1234}
    };

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c;
        int wbase;

        // R2: fetch timing
        boot();
        load(11'h000, 16'h1100);
        load(11'h100, 16'h0005);
        go();
        check(mem_rd && mem_addr == 11'h000 && phase_o == 2'b00, "R2 fetch t1 read", {mem_rd, mem_addr}, {1'b1, 11'h000});
        @(negedge clk);
        check(step_o == 3'd1 && pc_o == 11'h000, "R2 fetch t2 pc", pc_o, 0);
        @(negedge clk);
        check(step_o == 3'd2 && pc_o == 11'h001, "R2 fetch t3 pc", pc_o, 1);

        // R4: ADD vector table
        for (int i = 0; i < 4; i++) begin
            boot();
            load(11'h000, 16'h1100);
            load(11'h001, 16'h1101);
            load(11'h100, ADD_VEC[i][47:32]);
            load(11'h101, ADD_VEC[i][31:16]);
            go();
            run_instr(c);
            check(c == 6, "R4 add cycles", c, 6);
            run_instr(c);
            check(acc_o == ADD_VEC[i][15:0], "R4 add sum", acc_o, ADD_VEC[i][15:0]);
        end

        // R5: ISZ wrap to zero and no wrap
        for (int k = 0; k < 2; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'hFFFF : 16'h0005;
            boot();
            load(11'h000, 16'h2100);
            load(11'h100, v);
            go();
            run_instr(c);
            check(c == 7, "R5 isz cycles", c, 7);
            check(mem[11'h100] == v + 16'h1, "R5 isz store", mem[11'h100], v + 16'h1);
            check(pc_o == ((k == 0) ? 11'h002 : 11'h001), "R5 isz skip", pc_o, (k == 0) ? 2 : 1);
        end

        // R6: BSA
        boot();
        load(11'h000, 16'h3200);
        load(11'h201, 16'h1300);
        load(11'h300, 16'h0007);
        go();
        run_instr(c);
        check(c == 6, "R6 bsa cycles", c, 6);
        check(mem[11'h200] == 16'h0001 && pc_o == 11'h201, "R6 bsa return/pc", {mem[11'h200], 5'd0, pc_o}, {16'h0001, 5'd0, 11'h201});
        run_instr(c);
        check(acc_o == 16'h0007, "R6 resume after target", acc_o, 7);

        // R3: indirect ADD
        boot();
        load(11'h000, 16'h1850);
        load(11'h050, 16'h0123);
        load(11'h123, 16'h0042);
        go();
        run_instr(c);
        check(c == 9, "R3 indirect cycles", c, 9);
        check(acc_o == 16'h0042, "R3 indirect operand", acc_o, 16'h42);

        // R7: unknown opcode
        boot();
        load(11'h000, 16'hF000);
        load(11'h001, 16'h1100);
        load(11'h100, 16'h0009);
        go();
        wbase = wr_count;
        run_instr(c);
        check(c == 4, "R7 nop cycles", c, 4);
        check(pc_o == 11'h001 && acc_o == 16'h0000, "R7 nop state", acc_o, 0);
        check(wr_count == wbase, "R7 nop no write", wr_count - wbase, 0);
        run_instr(c);
        check(acc_o == 16'h0009, "R7 next instr", acc_o, 9);

        // R8: interrupt entry, then suppression
        boot();
        irq = 1'b1;
        load(11'h000, 16'h1100);
        load(11'h100, 16'h0003);
        load(11'h7F1, 16'hF000);
        go();
        wbase = int_entries;
        run_instr(c);
        check(c == 9, "R8 instr plus irq cycles", c, 9);
        check(mem[11'h7F0] == 16'h0001, "R8 saved pc", mem[11'h7F0], 1);
        check(pc_o == 11'h7F1, "R8 routine pc", pc_o, 11'h7F1);
        run_instr(c);
        check(c == 4 && pc_o == 11'h7F2, "R8 second irq blocked", {c[15:0], 5'd0, pc_o}, {16'd4, 5'd0, 11'h7F2});
        check(int_entries - wbase == 1, "R8 entry count", int_entries - wbase, 1);
        irq = 1'b0;

        // R1: reset clears state
        rst_n = 1'b0;
        @(negedge clk);
        check(pc_o == 11'h000 && acc_o == 16'h0000, "R1 reset regs", {5'd0, pc_o, acc_o}, 0);
        check(phase_o == 2'b00 && step_o == 3'd0, "R1 reset phase", {phase_o, step_o}, 0);

        // R9 and R10 port monitors
        check(overlap_count == 0, "R9 rd/wr overlap", overlap_count, 0);
        check(restart_errs == 0, "R10 step restart", restart_errs, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule